// File: doc/BRIEF.md
# DMA Channel Priority Tracker

This block records which of six DMA channels owns the transfer engine. It also records, for one level only, which channel was set aside when channel 1 took over. Each channel raises its request line while it wants service. The engine pulses a completion strobe when the owning channel's transfer ends. A mode input lets channel 1 break into a running transfer of any other channel.

Without that mode, all six channels share the engine in round-robin order, and a transfer always runs to its completion strobe. With the mode on, a channel-1 request does one of two things. It wins the next arbitration. Or, if another channel is mid-transfer, it takes over on the next cycle and the displaced channel's code goes into a shadow register. When channel 1 then completes, the displaced channel is put back as the owner.

The outputs are the owner code, the shadow code, a one-hot grant vector, and a 16-bit status word that packs both codes for a read-only view.

Top module: `dma_priority_tracker`

## Requirements
- R1: After reset, `active_code`, `shadow_code`, `grant` and `status_word` are all 0, and the round-robin search starts at channel 1.
- R2: Codes 1 to 6 name channels 1 to 6, and code 0 means idle or nothing pending. Channel k requests on `chan_req` bit k-1. `grant` has only bit k-1 set while `active_code` is k, and is all zeros while `active_code` is 0.
- R3: `status_word` bits 2:0 carry `active_code` and bits 6:4 carry `shadow_code`. Bit 3 and bits 15:7 are always 0.
- R4: An arbitration happens when `active_code` is 0, or when `xfer_done` is high and no restore applies. Its result appears one clock later. The winner is the first requesting channel found by searching upward, with wrap-around, from the channel after the one last picked by arbitration. If no channel requests, `active_code` becomes 0.
- R5: While a channel is active and `xfer_done` is low, `active_code` keeps its value whatever `chan_req` does, unless R7 applies.
- R6: When `ch1_hp_en` is high and `chan_req[0]` is high, an arbitration picks channel 1 whatever the round-robin position.
- R7: Preemption: `ch1_hp_en` is high, `chan_req[0]` is high, `xfer_done` is low and `active_code` is between 2 and 6. One clock later, `active_code` is 1 and `shadow_code` holds the previous `active_code`.
- R8: Restore: `xfer_done` is high while `active_code` is 1 and `shadow_code` is non-zero. One clock later, `active_code` equals the old shadow and `shadow_code` is 0, whatever the requests are.
- R9: When `xfer_done` ends a transfer of channels 2 to 6 in the same cycle that channel 1 requests under high-priority mode, the strobe wins. Channel 1 is granted through arbitration and `shadow_code` stays 0.
- R10: While `ch1_hp_en` is low, channel 1 never preempts and a zero `shadow_code` stays 0. Channel 1 takes part in round-robin like any other channel.
- R11: A preemption or a restore leaves the round-robin position unchanged. While channel 1 is active, a further channel-1 request nests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | 6 | Request per channel, bit 0 is channel 1 |
| xfer_done | input | 1 | Completion strobe for the owning channel |
| ch1_hp_en | input | 1 | Allows channel 1 to win and to preempt |
| active_code | output | 3 | Code of the owning channel, 0 when idle |
| shadow_code | output | 3 | Code of the channel displaced by channel 1 |
| grant | output | 6 | One-hot grant decoded from `active_code` |
| status_word | output | 16 | Packed read-only view of both codes |

## Verification
Two events can land on the same edge: a completion strobe for a channel other than channel 1, and a channel-1 request under high-priority mode that would otherwise preempt. The bench sets up a channel-2 transfer and then raises `xfer_done` and `chan_req[0]` together. It expects channel 1 on the next cycle with a zero shadow, not a save of a channel that has already finished. It also raises a channel-1 request during the completion of a preempting service, and expects the restore to win so that the displaced channel comes back.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

   // Decision taken by the tracker on each clock edge.
   typedef enum logic [1:0] {
      EV_HOLD    = 2'd0,
      EV_ARB     = 2'd1,
      EV_PREEMPT = 2'd2,
      EV_RESTORE = 2'd3
   } track_ev_e;

   // Bits needed to hold codes 0..n (0 reserved for "none").
   function automatic int unsigned code_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // Bits needed to index n channels.
   function automatic int unsigned index_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dma_rr_picker.sv
// Round-robin search over requesters starting after ptr, with an optional
// override that lets channel index 0 win outright.
module dma_rr_picker #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned CODE_W = 3
) (
   input  logic [NUM_CH-1:0] req,
   input  logic [IDX_W-1:0]  ptr,
   input  logic              hp_en,
   output logic              valid,
   output logic [IDX_W-1:0]  idx,
   output logic [CODE_W-1:0] code
);
   localparam int unsigned SUM_W = IDX_W + 1;

   logic             found;
   logic [IDX_W-1:0] pick;

   always_comb begin
      logic [SUM_W-1:0] cand;
      found = 1'b0;
      pick  = '0;
      cand  = '0;
      for (int k = 1; k <= int'(NUM_CH); k++) begin
         cand = {1'b0, ptr} + SUM_W'(k);
         if (cand >= SUM_W'(NUM_CH)) begin
            cand = cand - SUM_W'(NUM_CH);
         end
         if (!found && req[cand[IDX_W-1:0]]) begin
            found = 1'b1;
            pick  = cand[IDX_W-1:0];
         end
      end
      if (hp_en && req[0]) begin
         found = 1'b1;
         pick  = '0;
      end
   end

   assign valid = found;
   assign idx   = pick;
   assign code  = CODE_W'(pick) + CODE_W'(1);

endmodule

// File: rtl/dma_grant_decode.sv
// Turns a channel code into a one-hot grant; code 0 gives no grant.
module dma_grant_decode #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output logic [NUM_CH-1:0] grant
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
      assign grant[g] = (code == CODE_W'(g + 1));
   end
endmodule

// File: rtl/dma_status_pack.sv
// Packs the owner and shadow codes into a read-only word with a zero
// separator bit between them and zero padding above.
module dma_status_pack #(
   parameter int unsigned STAT_W = 16,
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] active,
   input  logic [CODE_W-1:0] shadow,
   output logic [STAT_W-1:0] word
);
   localparam int unsigned SH_LSB = CODE_W + 1;
   localparam int unsigned SH_MSB = SH_LSB + CODE_W - 1;

   assign word[CODE_W-1:0]      = active;
   assign word[CODE_W]          = 1'b0;
   assign word[SH_MSB:SH_LSB]   = shadow;

   if (STAT_W > SH_MSB + 1) begin : g_pad
      assign word[STAT_W-1:SH_MSB+1] = '0;
   end
endmodule

// File: rtl/dma_priority_tracker.sv
module dma_priority_tracker
   import dma_prio_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned STAT_W = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [NUM_CH-1:0]                      chan_req,
   input  logic                                   xfer_done,
   input  logic                                   ch1_hp_en,
   output logic [dma_prio_pkg::code_width(NUM_CH)-1:0] active_code,
   output logic [dma_prio_pkg::code_width(NUM_CH)-1:0] shadow_code,
   output logic [NUM_CH-1:0]                      grant,
   output logic [STAT_W-1:0]                      status_word
);
   localparam int unsigned CODE_W = code_width(NUM_CH);
   localparam int unsigned IDX_W  = index_width(NUM_CH);
   localparam logic [CODE_W-1:0] HP_CODE = CODE_W'(1);
   localparam logic [IDX_W-1:0]  PTR_RST = IDX_W'(NUM_CH - 1);

   // Elaboration-time parameter checks.
   if (NUM_CH < 2) begin : g_chk_ch
      $error("dma_priority_tracker: NUM_CH must be at least 2");
   end
   if (STAT_W < 2 * CODE_W + 1) begin : g_chk_stat
      $error("dma_priority_tracker: STAT_W too narrow for both codes");
   end

   logic [CODE_W-1:0] act_q, sh_q;
   logic [IDX_W-1:0]  ptr_q;
   track_ev_e         ev;

   logic              arb_valid;
   logic [IDX_W-1:0]  arb_idx;
   logic [CODE_W-1:0] arb_code;

   dma_rr_picker #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W),
      .CODE_W (CODE_W)
   ) u_picker (
      .req   (chan_req),
      .ptr   (ptr_q),
      .hp_en (ch1_hp_en),
      .valid (arb_valid),
      .idx   (arb_idx),
      .code  (arb_code)
   );

   // Event selection: completion outranks preemption; restore outranks
   // arbitration when channel 1 finishes with a saved channel.
   always_comb begin
      ev = EV_HOLD;
      if (act_q == '0) begin
         ev = EV_ARB;
      end else if (xfer_done) begin
         if (act_q == HP_CODE && sh_q != '0) ev = EV_RESTORE;
         else                                ev = EV_ARB;
      end else if (ch1_hp_en && chan_req[0] && act_q != HP_CODE) begin
         ev = EV_PREEMPT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         sh_q  <= '0;
         ptr_q <= PTR_RST;
      end else begin
         unique case (ev)
            EV_ARB: begin
               sh_q <= '0;
               if (arb_valid) begin
                  act_q <= arb_code;
                  ptr_q <= arb_idx;
               end else begin
                  act_q <= '0;
               end
            end
            EV_PREEMPT: begin
               sh_q  <= act_q;
               act_q <= HP_CODE;
            end
            EV_RESTORE: begin
               act_q <= sh_q;
               sh_q  <= '0;
            end
            default: ;
         endcase
      end
   end

   dma_grant_decode #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) u_decode (
      .code  (act_q),
      .grant (grant)
   );

   dma_status_pack #(
      .STAT_W (STAT_W),
      .CODE_W (CODE_W)
   ) u_pack (
      .active (act_q),
      .shadow (sh_q),
      .word   (status_word)
   );

   assign active_code = act_q;
   assign shadow_code = sh_q;

endmodule

// File: rtl/dma_priority_tracker_chk.sv
module dma_priority_tracker_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned STAT_W = 16,
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] chan_req,
   input logic              xfer_done,
   input logic              ch1_hp_en,
   input logic [CODE_W-1:0] active_code,
   input logic [CODE_W-1:0] shadow_code,
   input logic [NUM_CH-1:0] grant,
   input logic [STAT_W-1:0] status_word
);
   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   assert_grant_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_code == '0) ? (grant == '0)
                          : (grant == (NUM_CH'(1) << (active_code - ONE))));

   assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_code <= CODE_W'(NUM_CH)) && (shadow_code <= CODE_W'(NUM_CH)));

   assert_status_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[CODE_W] == 1'b0) &&
      ((status_word >> (2 * CODE_W + 1)) == '0) &&
      (status_word[CODE_W-1:0] == active_code) &&
      (status_word[2*CODE_W:CODE_W+1] == shadow_code));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_code != '0 && !xfer_done && !(ch1_hp_en && chan_req[0]))
      |=> $stable(active_code));

   assert_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch1_hp_en && chan_req[0] && !xfer_done &&
       active_code != '0 && active_code != ONE)
      |=> (active_code == ONE) && (shadow_code == $past(active_code)));

   assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && active_code == ONE && shadow_code != '0)
      |=> (active_code == $past(shadow_code)) && (shadow_code == '0));

   assert_done_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && ch1_hp_en && chan_req[0] &&
       active_code != '0 && active_code != ONE)
      |=> (active_code == ONE) && (shadow_code == '0));

   assert_no_shadow_without_hp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch1_hp_en && shadow_code == '0) |=> (shadow_code == '0));

   assert_no_nesting_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_code == ONE && !xfer_done) |=> $stable(shadow_code));

endmodule

bind dma_priority_tracker dma_priority_tracker_chk #(
   .NUM_CH (NUM_CH),
   .STAT_W (STAT_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chan_req    (chan_req),
   .xfer_done   (xfer_done),
   .ch1_hp_en   (ch1_hp_en),
   .active_code (active_code),
   .shadow_code (shadow_code),
   .grant       (grant),
   .status_word (status_word)
);

// File: tb/test_dma_priority_tracker.sv
module test_dma_priority_tracker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  chan_req = '0;
   logic        xfer_done = 1'b0;
   logic        ch1_hp_en = 1'b0;
   logic [2:0]  active_code;
   logic [2:0]  shadow_code;
   logic [5:0]  grant;
   logic [15:0] status_word;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_priority_tracker i_dma_priority_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_req    (chan_req),
      .xfer_done   (xfer_done),
      .ch1_hp_en   (ch1_hp_en),
      .active_code (active_code),
      .shadow_code (shadow_code),
      .grant       (grant),
      .status_word (status_word)
   );

   task automatic check_val(input string tag, input string what,
                            input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Expected grant and status follow from R2 and R3.
   task automatic expect_state(input string tag, input int a, input int s);
      int eg;
      int es;
      eg = (a == 0) ? 0 : (1 << (a - 1));
      es = (s << 4) | a;
      check_val(tag, "active", int'(active_code), a);
      check_val(tag, "shadow", int'(shadow_code), s);
      check_val({tag, "/R2"}, "grant", int'(grant), eg);
      check_val({tag, "/R3"}, "status", int'(status_word), es);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic [5:0] r, input logic d, input logic h);
      chan_req  = r;
      xfer_done = d;
      ch1_hp_en = h;
   endtask

   task automatic apply_reset();
      drive(6'b0, 1'b0, 1'b0);
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   // R1: reset state; R4: full rotation.
   task automatic t_reset_and_rotation();
      apply_reset();
      expect_state("R1 reset", 0, 0);
      drive(6'b111111, 1'b0, 1'b0);
      step();
      expect_state("R4 first pick", 1, 0);
      drive(6'b111111, 1'b1, 1'b0);
      for (int c = 2; c <= 6; c++) begin
         step();
         expect_state("R4 rotation", c, 0);
      end
      step();
      expect_state("R4 wrap", 1, 0);
   endtask

   // R4 sparse requests, R5 hold, idle when nothing requests.
   task automatic t_sparse_and_hold();
      apply_reset();
      drive(6'b100100, 1'b0, 1'b0);
      step();
      expect_state("R4 sparse first", 3, 0);
      drive(6'b111111, 1'b0, 1'b0);
      step();
      expect_state("R5 hold all req", 3, 0);
      drive(6'b000000, 1'b0, 1'b0);
      step();
      expect_state("R5 hold no req", 3, 0);
      drive(6'b100100, 1'b1, 1'b0);
      step();
      expect_state("R4 sparse next", 6, 0);
      step();
      expect_state("R4 sparse wrap", 3, 0);
      drive(6'b000000, 1'b1, 1'b0);
      step();
      expect_state("R4 none requesting", 0, 0);
      drive(6'b000000, 1'b0, 1'b0);
      step();
      expect_state("R4 stays idle", 0, 0);
   endtask

   // R6: channel 1 wins arbitration only under high-priority mode.
   task automatic t_hp_arbitration();
      apply_reset();
      drive(6'b000001, 1'b0, 1'b0);
      step();
      expect_state("R6 setup", 1, 0);
      drive(6'b000011, 1'b1, 1'b1);
      step();
      expect_state("R6 ch1 wins", 1, 0);
      drive(6'b000011, 1'b1, 1'b0);
      step();
      expect_state("R6 rr without hp", 2, 0);
   endtask

   // R7 preempt, R11 no nesting, R8 restore with requests up, R11 pointer.
   task automatic t_preempt_restore();
      apply_reset();
      drive(6'b001000, 1'b0, 1'b1);
      step();
      expect_state("R7 setup", 4, 0);
      drive(6'b001001, 1'b0, 1'b1);
      step();
      expect_state("R7 preempt", 1, 4);
      step();
      expect_state("R11 no nesting", 1, 4);
      drive(6'b001001, 1'b1, 1'b1);
      step();
      expect_state("R8 restore", 4, 0);
      drive(6'b001000, 1'b0, 1'b1);
      step();
      expect_state("R8 resumed holds", 4, 0);
      drive(6'b111110, 1'b1, 1'b0);
      step();
      expect_state("R11 pointer kept", 5, 0);
   endtask

   // R9: completion and channel-1 request in the same cycle.
   task automatic t_done_collision();
      apply_reset();
      drive(6'b000010, 1'b0, 1'b1);
      step();
      expect_state("R9 setup", 2, 0);
      drive(6'b000011, 1'b1, 1'b1);
      step();
      expect_state("R9 done wins", 1, 0);
      drive(6'b000010, 1'b1, 1'b1);
      step();
      expect_state("R9 no restore", 2, 0);
   endtask

   // R10: without high-priority mode channel 1 waits its turn.
   task automatic t_no_hp();
      apply_reset();
      drive(6'b000100, 1'b0, 1'b0);
      step();
      expect_state("R10 setup", 3, 0);
      drive(6'b000101, 1'b0, 1'b0);
      step();
      expect_state("R10 no preempt", 3, 0);
      step();
      expect_state("R10 still held", 3, 0);
      drive(6'b000101, 1'b1, 1'b0);
      step();
      expect_state("R10 rr to ch1", 1, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset_and_rotation();
      t_sparse_and_hold();
      t_hp_arbitration();
      t_preempt_restore();
      t_done_collision();
      t_no_hp();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule